// File: doc/BRIEF.md
# Legacy video memory window decoder

This block decides whether a host memory access falls inside the legacy video aperture while the adapter runs in its linear, chained pixel mode. It does so only when every bit plane is write-enabled and the chain-4 memory mode is on. In that case it reports a hit and translates the host address into a byte offset in video RAM. A 2-bit map selector chooses where the aperture sits and how large it is. One setting covers a 128 KiB span. One exposes a 64 KiB window that is moved through video RAM by a bank register. The other two give the 32 KiB monochrome and colour text areas.

The configuration inputs are registered once per cycle. A lookup is answered one cycle after its valid strobe, using the configuration held when the lookup was sampled. When an active window is replaced by a different one, or switched off, the block raises a single-cycle "planes dirty" pulse. This pulse tells the display side that all four planes must be treated as updated.

Top module: `vwin_decoder`

## Requirements
- R1: The window is active only when the plane write mask is all ones (4'hF) and chain-4 is set; with any other mask, or with chain-4 clear, no lookup ever hits.
- R2: The map selector code is taken directly from the 2-bit input, where 0, 1, 2 and 3 select the four layouts of R3 to R6.
- R3: Map code 0 hits for host addresses 0xA0000 through 0xBFFFF and returns (address - 0xA0000) as the VRAM offset.
- R4: Map code 1 hits for 0xA0000 through 0xAFFFF and returns (address - 0xA0000) + bank * 0x10000.
- R5: Map code 2 hits for 0xB0000 through 0xB7FFF and returns (address - 0xB0000).
- R6: Map code 3 hits for 0xB8000 through 0xBFFFF and returns (address - 0xB8000).
- R7: hit_o and vram_addr_o reflect the lookup sampled at the previous clock edge. A configuration change takes effect for lookups sampled one edge after it was sampled.
- R8: vram_addr_o changes only on a hit and otherwise holds its last value.
- R9: planes_dirty_o is high for exactly the cycle in which a new window configuration takes effect, and only if the configuration it replaces was active and differs in activity, base, size or offset.
- R10: A bank change while a map other than code 1 is selected has no effect on translation and raises no dirty pulse.
- R11: During and right after reset, hit_o, vram_addr_o and planes_dirty_o are zero and the window is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| plane_wr_mask_i | input | PLANES | Sequencer plane write-enable mask |
| chain4_i | input | 1 | Chain-4 memory mode enable |
| map_sel_i | input | 2 | Memory map select code |
| bank_i | input | BANK_W | Bank number for map code 1 (64 KiB units) |
| addr_valid_i | input | 1 | Host lookup strobe |
| host_addr_i | input | ADDR_W | Host physical address |
| hit_o | output | 1 | Previous lookup fell inside the active window |
| vram_addr_o | output | VRAM_AW | Translated VRAM byte offset |
| planes_dirty_o | output | 1 | One-cycle pulse: active window replaced or removed |

## Verification
The bench probes both edges of every window: the first and last address inside each window, and the first address below and above it. A decoder with an off-by-one limit, or with the wrong size for a map code, would then hit one address too many or too few. It changes the configuration and issues lookups in the same cycle. A decoder that used the new configuration a cycle early would translate with the wrong base. It toggles the bank under map codes 1 and 3, so a design that let the bank leak into the other maps, or that pulsed dirty on a change that did not matter, shows up at the outputs. It also switches the window on from the inactive state, which must not pulse, and switches it off from the active state, which must pulse.

// File: rtl/vwin_pkg.sv
package vwin_pkg;
  typedef enum logic [1:0] {
    MAP_WIDE   = 2'd0,
    MAP_BANKED = 2'd1,
    MAP_MONO   = 2'd2,
    MAP_COLOR  = 2'd3
  } map_e;

  localparam int unsigned LO_BASE    = 32'h000A_0000;
  localparam int unsigned MONO_BASE  = 32'h000B_0000;
  localparam int unsigned COLOR_BASE = 32'h000B_8000;
  localparam int unsigned WIDE_SIZE  = 32'h0002_0000;
  localparam int unsigned BANK_SIZE  = 32'h0001_0000;
  localparam int unsigned TEXT_SIZE  = 32'h0000_8000;
  localparam int          BANK_SHIFT = 16;
endpackage

// File: rtl/vwin_cfg_sel.sv
module vwin_cfg_sel
  import vwin_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int VRAM_AW = 24,
  parameter int BANK_W  = 8,
  parameter int PLANES  = 4
) (
  input  logic [PLANES-1:0]  plane_mask_i,
  input  logic               chain4_i,
  input  logic [1:0]         map_sel_i,
  input  logic [BANK_W-1:0]  bank_i,
  output logic               act_o,
  output logic [ADDR_W-1:0]  base_o,
  output logic [ADDR_W:0]    size_o,
  output logic [VRAM_AW-1:0] off_o
);
  localparam int BANK_SPAN = BANK_W + BANK_SHIFT;
  localparam int SIZE_W    = ADDR_W + 1;

  logic [VRAM_AW-1:0] bank_bytes;

  generate
    if (VRAM_AW >= BANK_SPAN) begin : g_bank_pad
      assign bank_bytes = VRAM_AW'({bank_i, {BANK_SHIFT{1'b0}}});
    end else begin : g_bank_trunc
      logic [BANK_SPAN-1:0] bank_full;
      assign bank_full  = {bank_i, {BANK_SHIFT{1'b0}}};
      assign bank_bytes = bank_full[VRAM_AW-1:0];
    end
  endgenerate

  always_comb begin
    act_o  = (plane_mask_i == {PLANES{1'b1}}) && chain4_i;
    base_o = '0;
    size_o = '0;
    off_o  = '0;
    if (act_o) begin
      unique case (map_e'(map_sel_i))
        MAP_WIDE: begin
          base_o = ADDR_W'(LO_BASE);
          size_o = SIZE_W'(WIDE_SIZE);
        end
        MAP_BANKED: begin
          base_o = ADDR_W'(LO_BASE);
          size_o = SIZE_W'(BANK_SIZE);
          off_o  = bank_bytes;
        end
        MAP_MONO: begin
          base_o = ADDR_W'(MONO_BASE);
          size_o = SIZE_W'(TEXT_SIZE);
        end
        default: begin
          base_o = ADDR_W'(COLOR_BASE);
          size_o = SIZE_W'(TEXT_SIZE);
        end
      endcase
    end
  end
endmodule

// File: rtl/vwin_cfg_reg.sv
module vwin_cfg_reg #(
  parameter int ADDR_W  = 20,
  parameter int VRAM_AW = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               nxt_act_i,
  input  logic [ADDR_W-1:0]  nxt_base_i,
  input  logic [ADDR_W:0]    nxt_size_i,
  input  logic [VRAM_AW-1:0] nxt_off_i,
  output logic               act_o,
  output logic [ADDR_W-1:0]  base_o,
  output logic [ADDR_W:0]    size_o,
  output logic [VRAM_AW-1:0] off_o,
  output logic               dirty_o
);
  logic               act_q;
  logic [ADDR_W-1:0]  base_q;
  logic [ADDR_W:0]    size_q;
  logic [VRAM_AW-1:0] off_q;
  logic               dirty_q;
  logic               cfg_change;
  logic               dirty_d;

  always_comb begin
    cfg_change = (nxt_act_i != act_q) || (nxt_base_i != base_q) ||
                 (nxt_size_i != size_q) || (nxt_off_i != off_q);
    dirty_d    = act_q && cfg_change;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      base_q <= '0;
      size_q <= '0;
      off_q  <= '0;
    end else if (cfg_change) begin
      act_q  <= nxt_act_i;
      base_q <= nxt_base_i;
      size_q <= nxt_size_i;
      off_q  <= nxt_off_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dirty_q <= 1'b0;
    else         dirty_q <= dirty_d;
  end

  assign act_o   = act_q;
  assign base_o  = base_q;
  assign size_o  = size_q;
  assign off_o   = off_q;
  assign dirty_o = dirty_q;
endmodule

// File: rtl/vwin_addr_dec.sv
module vwin_addr_dec #(
  parameter int ADDR_W  = 20,
  parameter int VRAM_AW = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               act_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [ADDR_W:0]    size_i,
  input  logic [VRAM_AW-1:0] off_i,
  output logic               hit_o,
  output logic [VRAM_AW-1:0] vram_o
);
  logic [ADDR_W:0]    win_end;
  logic               in_win;
  logic               look_hit;
  logic [ADDR_W-1:0]  rel;
  logic [VRAM_AW-1:0] vram_d;
  logic               hit_q;
  logic [VRAM_AW-1:0] vram_q;

  always_comb begin
    win_end  = {1'b0, base_i} + size_i;
    in_win   = act_i && (addr_i >= base_i) && ({1'b0, addr_i} < win_end);
    look_hit = valid_i && in_win;
    rel      = addr_i - base_i;
    vram_d   = VRAM_AW'(rel) + off_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_q <= 1'b0;
    else         hit_q <= look_hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       vram_q <= '0;
    else if (look_hit) vram_q <= vram_d;
  end

  assign hit_o  = hit_q;
  assign vram_o = vram_q;
endmodule

// File: rtl/vwin_decoder.sv
module vwin_decoder #(
  parameter int ADDR_W  = 20,
  parameter int VRAM_AW = 24,
  parameter int BANK_W  = 8,
  parameter int PLANES  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PLANES-1:0]  plane_wr_mask_i,
  input  logic               chain4_i,
  input  logic [1:0]         map_sel_i,
  input  logic [BANK_W-1:0]  bank_i,
  input  logic               addr_valid_i,
  input  logic [ADDR_W-1:0]  host_addr_i,
  output logic               hit_o,
  output logic [VRAM_AW-1:0] vram_addr_o,
  output logic               planes_dirty_o
);
  logic               nxt_act;
  logic [ADDR_W-1:0]  nxt_base;
  logic [ADDR_W:0]    nxt_size;
  logic [VRAM_AW-1:0] nxt_off;
  logic               cur_act;
  logic [ADDR_W-1:0]  cur_base;
  logic [ADDR_W:0]    cur_size;
  logic [VRAM_AW-1:0] cur_off;

  vwin_cfg_sel #(.ADDR_W(ADDR_W), .VRAM_AW(VRAM_AW), .BANK_W(BANK_W), .PLANES(PLANES)) i_sel (
    .plane_mask_i(plane_wr_mask_i), .chain4_i(chain4_i), .map_sel_i(map_sel_i),
    .bank_i(bank_i), .act_o(nxt_act), .base_o(nxt_base), .size_o(nxt_size), .off_o(nxt_off)
  );

  vwin_cfg_reg #(.ADDR_W(ADDR_W), .VRAM_AW(VRAM_AW)) i_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .nxt_act_i(nxt_act), .nxt_base_i(nxt_base), .nxt_size_i(nxt_size), .nxt_off_i(nxt_off),
    .act_o(cur_act), .base_o(cur_base), .size_o(cur_size), .off_o(cur_off),
    .dirty_o(planes_dirty_o)
  );

  vwin_addr_dec #(.ADDR_W(ADDR_W), .VRAM_AW(VRAM_AW)) i_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(addr_valid_i), .addr_i(host_addr_i),
    .act_i(cur_act), .base_i(cur_base), .size_i(cur_size), .off_i(cur_off),
    .hit_o(hit_o), .vram_o(vram_addr_o)
  );

  p_hit_follows_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $past(addr_valid_i));

  p_hit_needs_window_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $past((plane_wr_mask_i == {PLANES{1'b1}}) && chain4_i, 2));

  p_dirty_needs_window_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    planes_dirty_o |-> $past((plane_wr_mask_i == {PLANES{1'b1}}) && chain4_i, 2));

  p_addr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> $stable(vram_addr_o));

  // All window bases and bank offsets are multiples of 0x8000 (R3..R6)
  p_low_bits_kept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (vram_addr_o[14:0] == $past(host_addr_i[14:0])));
endmodule

// File: tb/test_vwin_decoder.sv
`timescale 1ns/1ps
module test_vwin_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  mask;
  logic        c4;
  logic [1:0]  msel;
  logic [7:0]  bank;
  logic        valid;
  logic [19:0] addr;
  logic        hit;
  logic [23:0] vram;
  logic        dirty;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;
  string phase  = "R11";

  // reference model state
  bit          m_act;
  int          m_base, m_size, m_off;
  bit          e_hit, e_dirty;
  logic [23:0] e_addr;

  always #5 clk = ~clk;

  vwin_decoder i_vwin_decoder (
    .clk_i(clk), .rst_ni(rst_n), .plane_wr_mask_i(mask), .chain4_i(c4),
    .map_sel_i(msel), .bank_i(bank), .addr_valid_i(valid), .host_addr_i(addr),
    .hit_o(hit), .vram_addr_o(vram), .planes_dirty_o(dirty)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_base = 0; m_size = 0; m_off = 0;
      e_hit = 0; e_dirty = 0; e_addr = '0;
    end else begin
      bit n_act;
      int n_base, n_size, n_off, a;
      n_act = (mask == 4'hF) && c4;
      n_base = 0; n_size = 0; n_off = 0;
      if (n_act) begin
        if (msel == 2'd0)      begin n_base = 'hA0000; n_size = 'h20000; end
        else if (msel == 2'd1) begin n_base = 'hA0000; n_size = 'h10000; n_off = int'(bank) * 65536; end
        else if (msel == 2'd2) begin n_base = 'hB0000; n_size = 'h8000; end
        else                   begin n_base = 'hB8000; n_size = 'h8000; end
      end
      a = int'(addr);
      e_hit = valid && m_act && (a >= m_base) && (a < m_base + m_size);
      if (e_hit) e_addr = 24'(a - m_base + m_off);
      e_dirty = m_act && ((n_act != m_act) || (n_base != m_base) ||
                          (n_size != m_size) || (n_off != m_off));
      m_act = n_act; m_base = n_base; m_size = n_size; m_off = n_off;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks += 3;
      if (hit !== e_hit) begin
        errors++;
        $display("FAIL %s hit: actual=%0d expected=%0d", phase, hit, e_hit);
      end
      if (vram !== e_addr) begin
        errors++;
        $display("FAIL %s vram_addr: actual=%h expected=%h", phase, vram, e_addr);
      end
      if (dirty !== e_dirty) begin
        errors++;
        $display("FAIL R9 (%s) dirty: actual=%0d expected=%0d", phase, dirty, e_dirty);
      end
    end
  end

  task automatic cfg(input logic [3:0] m, input logic c, input logic [1:0] s, input logic [7:0] b);
    mask = m; c4 = c; msel = s; bank = b;
  endtask

  task automatic look(input logic v, input logic [19:0] a);
    @(negedge clk);
    valid = v; addr = a;
  endtask

  initial begin
    rst_n = 1'b0;
    cfg(4'h0, 1'b0, 2'd0, 8'h00);
    valid = 1'b0; addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    look(0, 20'h0);

    phase = "R1";
    cfg(4'hF, 1'b0, 2'd0, 8'h00); look(1, 20'hA0000); look(1, 20'hB0000);
    cfg(4'h7, 1'b1, 2'd0, 8'h00); look(1, 20'hA0000); look(1, 20'hA1234);
    cfg(4'hE, 1'b1, 2'd3, 8'h00); look(1, 20'hB8000); look(0, 20'h0);

    phase = "R3";
    cfg(4'hF, 1'b1, 2'd0, 8'h00);
    look(1, 20'hA0000); look(1, 20'hBFFFF); look(1, 20'hC0000);
    look(1, 20'h9FFFF); look(1, 20'hB1234); look(0, 20'h0);

    phase = "R4";
    cfg(4'hF, 1'b1, 2'd1, 8'h03);
    look(1, 20'hA0000); look(1, 20'hAFFFF); look(1, 20'hB0000);
    cfg(4'hF, 1'b1, 2'd1, 8'h05); look(1, 20'hA4321); look(1, 20'hA4321);
    cfg(4'hF, 1'b1, 2'd1, 8'hFF); look(1, 20'hAFFFF); look(1, 20'hAFFFF);

    phase = "R5";
    cfg(4'hF, 1'b1, 2'd2, 8'hFF);
    look(1, 20'hB0000); look(1, 20'hB7FFF); look(1, 20'hB8000); look(1, 20'hAFFFF);

    phase = "R6";
    cfg(4'hF, 1'b1, 2'd3, 8'hFF);
    look(1, 20'hB8000); look(1, 20'hBFFFF); look(1, 20'hB7FFF); look(1, 20'hC0000);

    phase = "R10";
    for (int i = 0; i < 6; i++) begin
      cfg(4'hF, 1'b1, 2'd3, 8'(i * 37));
      look(1, 20'hB9000 + 20'(i));
    end

    phase = "R8";
    look(0, 20'hB8888); look(1, 20'h12345); look(0, 20'hBA000); look(1, 20'hFFFFF);

    phase = "R7";
    cfg(4'hF, 1'b1, 2'd0, 8'h02); look(1, 20'hB9000);
    cfg(4'hF, 1'b1, 2'd1, 8'h02); look(1, 20'hA0010);
    look(1, 20'hA0010);
    cfg(4'hF, 1'b1, 2'd2, 8'h02); look(1, 20'hA0010); look(1, 20'hB0010);

    phase = "R9";
    cfg(4'hF, 1'b0, 2'd2, 8'h02); look(1, 20'hB0010); look(1, 20'hB0010);
    cfg(4'hF, 1'b1, 2'd2, 8'h02); look(1, 20'hB0010); look(1, 20'hB0010);
    cfg(4'h3, 1'b1, 2'd2, 8'h02); look(0, 20'h0); look(0, 20'h0);

    phase = "R2";
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 4; k++) begin
        cfg(4'hF, 1'b1, 2'(s), 8'h01);
        look(1, 20'hA0000 + 20'(k * 20'h7FFF));
      end
    end
    look(0, 20'h0); look(0, 20'h0);

    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL R7 watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule